// File: doc/BRIEF.md
# Bidirectional Latched Control Port

This block is a byte-wide parallel port that sits on a microprocessor bus and controls an external unit with six output channels and two sensor inputs. A write cycle (chip enable and write strobe both low) makes a write latch transparent. The lower six data bits then pass to the channel outputs. The value on the bus at the last clock of the cycle is held until the next write cycle.

A read latch keeps a copy of the channel state together with the live sensor bits. Between reads it refreshes this copy every clock. During a read cycle it freezes the copy and drives it onto the data bus through an output enable, which drops as soon as the read strobe rises. Control software typically writes a pattern such as 0x15 or 0x2A, reads it back and masks off the two sensor bits before comparing.

A manual emergency input, synchronised through two flops, forces every channel off while it is high. When it is released, the held value comes back without a new write. A status output marks whether the most recent cycle was a write or a read. Address decoding is done upstream; the port sees only a decoded chip enable. All strobes are taken as synchronous to `clk_i`.

Top module: `ctl_port`

## Requirements
- R1: While `cs_ni` and `wr_ni` are both low, `chan_o` equals `wr_data_i[5:0]` in the same cycle (transparent write), unless the emergency stop has taken effect.
- R2: The value on `wr_data_i[5:0]` at the last rising edge of a write cycle is held on `chan_o` until the next write cycle. Bits 7:6 of a write never reach any output channel, and bus activity outside a write cycle does not change `chan_o`.
- R3: `estop_i` passes through two synchronising flops. From the second rising edge with `estop_i` high, `chan_o` is all zero and `chan_en_o` is low. After release, the held value returns on `chan_o` with `chan_en_o` high, without a new write.
- R4: `rd_oe_o` is high exactly while `cs_ni` and `rd_ni` are low and `wr_ni` is high. It is never high during a write cycle. `rd_data_o` is zero whenever `rd_oe_o` is low.
- R5: Read data layout: bits 5:0 are the held channel value, shown even while the emergency stop is active. Bit 6 is `sensor_i[0]` and bit 7 is `sensor_i[1]`.
- R6: During a read cycle, `rd_data_o` is the copy captured at the last rising edge before the read began. Changes on `sensor_i` within the read are not shown.
- R7: Outside read cycles, the read copy is refreshed on every rising edge, so a read reflects sensor values present one clock before it starts.
- R8: `status_o` goes high at the rising edge that ends a write-cycle clock and low at the rising edge that ends a read-cycle clock. Otherwise it keeps its value.
- R9: After reset, `chan_o` is 0, `chan_en_o` is 1, `rd_oe_o` is 0 and `status_o` is 0.
- R10: If both strobes are low with chip enable low, the cycle is treated as a write only: no bus drive, and the status goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Decoded chip enable, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| wr_data_i | input | 8 | Data bus from the CPU |
| sensor_i | input | 2 | Sensor inputs from the controlled unit |
| estop_i | input | 1 | Emergency disable, active high, asynchronous |
| rd_data_o | output | 8 | Data bus toward the CPU |
| rd_oe_o | output | 1 | Bus driver enable for rd_data_o |
| chan_o | output | 6 | Output channels |
| chan_en_o | output | 1 | Channel driver enable, low when stopped |
| status_o | output | 1 | Last-cycle indicator, high after a write |

## Verification
The bench changes the data bus in the middle of a multi-clock write. A latch that captured the first clock, instead of the last, would hold the wrong value. It moves the sensors during a read, which a read latch that stays transparent would expose as a changing bus. It writes a value with bits 7:6 set, to catch a port that leaks them into the channels. It asserts the emergency stop both during a write and for a single clock, to catch a design that acts after the wrong number of edges or that loses the held value on release. Simultaneous strobes check that the bus is never driven while a write is under way.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  typedef struct packed {
    logic wr_act;
    logic rd_act;
  } bus_cyc_t;

  function automatic bus_cyc_t decode_cyc(input logic cs_n, input logic rd_n, input logic wr_n);
    bus_cyc_t c;
    c.wr_act = ~cs_n & ~wr_n;
    c.rd_act = ~cs_n & ~rd_n & wr_n;
    return c;
  endfunction
endpackage

// File: rtl/ctl_port_sync.sv
module ctl_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctl_port_wlatch.sv
module ctl_port_wlatch #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] view_o,
  output logic [W-1:0] held_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= '0;
    else if (load_i) held_q <= d_i;
  end

  // transparent while loading, frozen otherwise
  assign view_o = load_i ? d_i : held_q;
  assign held_o = held_q;
endmodule

// File: rtl/ctl_port_rlatch.sv
module ctl_port_rlatch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         freeze_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (!freeze_i) snap_q <= d_i;
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/ctl_port.sv
module ctl_port
  import ctl_port_pkg::*;
#(
  parameter int CH_W        = 6,
  parameter int SNS_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W      = CH_W + SNS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic [SNS_W-1:0] sensor_i,
  input  logic             estop_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             rd_oe_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             chan_en_o,
  output logic             status_o
);
  bus_cyc_t        cyc;
  logic [CH_W-1:0] chan_view;
  logic [CH_W-1:0] chan_held;
  logic [BUS_W-1:0] snap;
  logic            stop_s;
  logic            status_q;

  assign cyc = decode_cyc(cs_ni, rd_ni, wr_ni);

  ctl_port_wlatch #(.W(CH_W)) u_wlatch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cyc.wr_act),
    .d_i    (wr_data_i[CH_W-1:0]),
    .view_o (chan_view),
    .held_o (chan_held)
  );

  ctl_port_rlatch #(.W(BUS_W)) u_rlatch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .freeze_i (cyc.rd_act),
    .d_i      ({sensor_i, chan_view}),
    .snap_o   (snap)
  );

  ctl_port_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (estop_i),
    .q_o    (stop_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         status_q <= 1'b0;
    else if (cyc.wr_act) status_q <= 1'b1;
    else if (cyc.rd_act) status_q <= 1'b0;
  end

  assign chan_o    = stop_s ? '0 : chan_view;
  assign chan_en_o = ~stop_s;
  assign rd_oe_o   = cyc.rd_act;
  assign rd_data_o = cyc.rd_act ? snap : '0;
  assign status_o  = status_q;

  logic unused_held;
  assign unused_held = ^chan_held;
endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk #(
  parameter int CH_W  = 6,
  parameter int SNS_W = 2,
  localparam int BUS_W = CH_W + SNS_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             rd_ni,
  input logic             wr_ni,
  input logic             estop_i,
  input logic [BUS_W-1:0] rd_data_o,
  input logic             rd_oe_o,
  input logic [CH_W-1:0]  chan_o,
  input logic             chan_en_o,
  input logic             status_o
);
  logic [1:0] age_q;
  logic       armed;
  logic       wr_cyc;
  logic       rd_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign armed  = (age_q == 2'd3);
  assign wr_cyc = !cs_ni && !wr_ni;
  assign rd_cyc = !cs_ni && !rd_ni && wr_ni;

  a_r4_no_oe_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cyc |-> !rd_oe_o);

  a_r4_oe_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> (!cs_ni && !rd_ni));

  a_r6_frozen_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && rd_oe_o && $past(rd_oe_o)) |-> $stable(rd_data_o));

  a_r3_stop_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(estop_i) && $past(estop_i, 2)) |-> (!chan_en_o && chan_o == '0));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !wr_cyc && $past(!wr_cyc) && chan_en_o && $past(chan_en_o)) |-> $stable(chan_o));

  a_r8_status_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cyc |=> status_o);

  a_r8_status_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cyc |=> !status_o);
endmodule

bind ctl_port ctl_port_chk #(.CH_W(CH_W), .SNS_W(SNS_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rd_ni     (rd_ni),
  .wr_ni     (wr_ni),
  .estop_i   (estop_i),
  .rd_data_o (rd_data_o),
  .rd_oe_o   (rd_oe_o),
  .chan_o    (chan_o),
  .chan_en_o (chan_en_o),
  .status_o  (status_o)
);

// File: tb/ctl_port_test.sv
`timescale 1ns/1ps
module ctl_port_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [7:0] wr_data_i = 8'h00;
  logic [1:0] sensor_i = 2'b00;
  logic       estop_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_oe_o;
  logic [5:0] chan_o;
  logic       chan_en_o;
  logic       status_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [5:0] m_held = '0;
  logic [7:0] m_snap = '0;
  logic [1:0] m_sync = '0;
  logic       m_stat = 1'b0;

  always #5 clk = ~clk;

  ctl_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .wr_data_i(wr_data_i), .sensor_i(sensor_i), .estop_i(estop_i),
    .rd_data_o(rd_data_o), .rd_oe_o(rd_oe_o), .chan_o(chan_o),
    .chan_en_o(chan_en_o), .status_o(status_o)
  );

  function automatic bit m_wr();
    return !cs_ni && !wr_ni;
  endfunction
  function automatic bit m_rd();
    return !cs_ni && !rd_ni && wr_ni;
  endfunction
  function automatic logic [5:0] m_view();
    return m_wr() ? wr_data_i[5:0] : m_held;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_held = '0; m_snap = '0; m_sync = '0; m_stat = 1'b0;
    end else begin
      if (!m_rd()) m_snap = {sensor_i, m_view()};
      if (m_wr()) m_held = wr_data_i[5:0];
      m_sync = {m_sync[0], estop_i};
      if (m_wr()) m_stat = 1'b1;
      else if (m_rd()) m_stat = 1'b0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R1 R2 R3 chan", chan_o, m_sync[1] ? 6'h00 : m_view());
    chk("R3 chan_en", chan_en_o, !m_sync[1]);
    chk("R4 R10 oe", rd_oe_o, m_rd());
    chk("R5 R6 R7 rd_data", rd_data_o, m_rd() ? m_snap : 8'h00);
    chk("R8 status", status_o, m_stat);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cs_ni = 1; rd_ni = 1; wr_ni = 1;
  endtask
  task automatic wr(input logic [7:0] d);
    cs_ni = 0; wr_ni = 0; rd_ni = 1; wr_data_i = d;
  endtask
  task automatic rd();
    cs_ni = 0; rd_ni = 0; wr_ni = 1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #23;
    @(negedge clk);
    // R9 reset state
    chk("R9 chan", chan_o, 6'h00);
    chk("R9 chan_en", chan_en_o, 1'b1);
    chk("R9 oe", rd_oe_o, 1'b0);
    chk("R9 status", status_o, 1'b0);
    rst_ni = 1;
    @(posedge clk); #1;
    cyc(); cyc();

    // R1 transparent with data changing mid-write; R2 last value held
    wr(8'h3F); cyc();
    wr_data_i = 8'h15; cyc();
    idle(); wr_data_i = 8'hFF; cyc(); cyc();
    chk("R2 hold 0x15", chan_o, 6'h15);

    // R5 read back with mask, sensors 01
    sensor_i = 2'b01; cyc();
    rd(); @(negedge clk);
    chk("R5 masked readback", rd_data_o & 8'h3F, 8'h15);
    chk("R5 sensor bits", rd_data_o[7:6], 2'b01);
    cyc();
    // R6 sensor change during read is hidden
    sensor_i = 2'b10; cyc(); cyc();
    idle(); cyc();
    // R7 next read sees new sensors
    rd(); @(negedge clk);
    chk("R7 refreshed sensors", rd_data_o, 8'h95);
    cyc(); idle(); cyc();

    // R2 bits 7:6 ignored
    wr(8'hEA); cyc(); idle(); cyc();
    chk("R2 upper bits ignored", chan_o, 6'h2A);
    rd(); cyc(); idle(); cyc();

    // R3 emergency stop during a write, then release
    estop_i = 1; wr(8'h07); cyc(); cyc(); idle(); cyc(); cyc();
    chk("R3 stopped", {chan_en_o, chan_o}, 7'h00);
    rd(); @(negedge clk);
    chk("R5 held shown while stopped", rd_data_o[5:0], 6'h07);
    cyc(); idle();
    estop_i = 0; cyc(); cyc(); cyc();
    chk("R3 restore", {chan_en_o, chan_o}, 7'h47);
    // one-clock pulse
    estop_i = 1; cyc(); estop_i = 0; cyc(); cyc(); cyc();

    // R10 both strobes
    cs_ni = 0; rd_ni = 0; wr_ni = 0; wr_data_i = 8'h2A; cyc(); cyc();
    idle(); cyc();
    chk("R10 write wins", {status_o, chan_o}, 7'h6A);
    // R8 read clears status
    rd(); cyc(); idle(); cyc();
    chk("R8 cleared", status_o, 1'b0);

    // mixed pattern sweep
    for (int i = 0; i < 40; i++) begin
      sensor_i = i[1:0];
      case (i % 4)
        0: wr(8'(i * 37));
        1: idle();
        2: rd();
        default: begin idle(); wr_data_i = 8'(i * 11); end
      endcase
      cyc();
    end
    idle(); cyc();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule